// File: doc/BRIEF.md
# DMA Channel Run-Control Sequencer

This block decides, for a small multi-channel DMA engine, which channels may move data and when they must stop. Each channel has a length stored in a configuration register and a working count, kept apart from it, that drops by one for each operand the datapath finishes. A global run bit and a per-channel enable bit can each halt a channel. The halt takes effect only at an operand boundary, so an operand already granted always completes. A channel marked non-interruptible ignores both bits and runs until its count is exhausted.

A halted channel resumes from its remaining count when it is allowed to run again. A cancel strobe given while it is halted discards the working state and returns the channel to idle. The configuration length survives the cancel, so a later start repeats the same transfer. The block grants one operand at a time to the lowest-numbered runnable channel and holds that grant until the datapath reports the operand done.

Top module: `dma_run_ctrl`

## Requirements
- R1: While rst_ni is low, every channel reads idle, no grant is driven, op_busy_o is 0 and no done flag is raised.
- R2: A start on an idle channel whose configured length L is nonzero makes it active. After exactly L completed operands it returns to idle, and its done_o bit pulses for one cycle. Done pulses appear in the order in which channels finish.
- R3: At most one gnt_o bit is set at a time. A grant stays set until op_done_i, and a free grant goes to the lowest-numbered runnable channel, with op_ch_o giving its index.
- R4: When glb_en_i is 0, every channel that is not non-interruptible stops. A channel holding a grant first shows the draining state, completes that operand, and then shows suspended. A suspended channel receives no grant.
- R5: Clearing ch_en_i for one channel suspends only that channel, and the other channels keep running.
- R6: A channel with nonstop_i set never enters the draining or suspended state. It completes all of its operands even while glb_en_i or its ch_en_i is 0.
- R7: When the run condition returns, a suspended channel resumes with its remaining count, so the total number of operands across the suspension equals L.
- R8: cancel_i on a suspended channel returns it to idle with its working count cleared. The configured length is kept, so a new start without a configuration write runs L operands again.
- R9: cancel_i on an active or idle channel has no effect.
- R10: state_o[2i+1:2i] encodes channel i as 0 = idle, 1 = active, 2 = draining (operand in flight, suspend pending), 3 = suspended.
- R11: If cancel and a resume arrive in the same cycle on a suspended channel, the cancel wins and the channel goes idle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| glb_en_i | input | 1 | Global run bit, 0 halts all interruptible channels |
| ch_en_i | input | N_CH | Per-channel run bits |
| nonstop_i | input | N_CH | Per-channel non-interruptible mode |
| cancel_i | input | N_CH | Per-channel cancel strobe |
| start_i | input | N_CH | Per-channel start strobe |
| cfg_we_i | input | 1 | Configuration length write enable |
| cfg_ch_i | input | CH_W | Channel selected for the configuration write |
| cfg_len_i | input | CNT_W | Length value, in operands |
| op_done_i | input | 1 | Datapath finished the granted operand |
| gnt_o | output | N_CH | One-hot operand grant |
| op_busy_o | output | 1 | An operand is in flight |
| op_ch_o | output | CH_W | Index of the granted channel |
| state_o | output | 2*N_CH | Per-channel state, two bits each |
| done_o | output | N_CH | One-cycle transfer-complete pulse |

## Verification
Two events can fall in the same clock edge. One is a cancel arriving together with the re-enable that would resume the same suspended channel. The other is a disable arriving while that channel's operand is still in flight. The bench suspends a channel, then in one cycle raises its enable and pulses its cancel, and expects state 0 and no grant afterward. It also drops the global bit at a negative edge where the channel holds a grant and op_done_i is low, and expects the draining code one edge later, with the operand count grown by exactly one before the suspended code appears.

// File: rtl/dma_rc_pkg.sv
package dma_rc_pkg;
  typedef enum logic [1:0] {
    CH_IDLE  = 2'd0,
    CH_RUN   = 2'd1,
    CH_DRAIN = 2'd2,
    CH_HOLD  = 2'd3
  } ch_state_e;
endpackage

// File: rtl/dma_rc_chan.sv
module dma_rc_chan
  import dma_rc_pkg::*;
#(
  parameter int CNT_W = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             start_i,
  input  logic [CNT_W-1:0] len_i,
  input  logic             run_ok_i,
  input  logic             cancel_i,
  input  logic             gnt_i,
  input  logic             op_done_i,
  output logic             req_o,
  output ch_state_e        state_o,
  output logic             done_o
);
  logic [CNT_W-1:0] cnt_q;
  logic             fin;
  logic             last;

  assign fin   = gnt_i & op_done_i;
  assign last  = (cnt_q == CNT_W'(1));
  assign req_o = (state_o == CH_RUN) & run_ok_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_o <= CH_IDLE;
      cnt_q   <= '0;
      done_o  <= 1'b0;
    end else begin
      done_o <= 1'b0;
      unique case (state_o)
        CH_IDLE: if (start_i && len_i != '0) begin
          state_o <= CH_RUN;
          cnt_q   <= len_i;
        end
        CH_RUN: begin
          if (fin) begin
            cnt_q <= cnt_q - 1'b1;
            if (last) begin
              state_o <= CH_IDLE;
              done_o  <= 1'b1;
            end else if (!run_ok_i) begin
              state_o <= CH_HOLD;
            end
          end else if (!run_ok_i) begin
            state_o <= gnt_i ? CH_DRAIN : CH_HOLD;
          end
        end
        CH_DRAIN: begin
          if (fin) begin
            cnt_q <= cnt_q - 1'b1;
            if (last) begin
              state_o <= CH_IDLE;
              done_o  <= 1'b1;
            end else begin
              state_o <= run_ok_i ? CH_RUN : CH_HOLD;
            end
          end else if (run_ok_i) begin
            state_o <= CH_RUN;
          end
        end
        CH_HOLD: begin
          // cancel outranks resume
          if (cancel_i) begin
            state_o <= CH_IDLE;
            cnt_q   <= '0;
          end else if (run_ok_i) begin
            state_o <= CH_RUN;
          end
        end
        default: state_o <= CH_IDLE;
      endcase
    end
  end

  assert_cancel_idle_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_o == CH_HOLD && cancel_i) |=> (state_o == CH_IDLE && cnt_q == '0));

  assert_cancel_ignored_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_o == CH_RUN && cancel_i && run_ok_i && !fin) |=> (state_o == CH_RUN));

  assert_drain_inflight_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_o == CH_DRAIN) |-> gnt_i);

  assert_done_source_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> $past(fin));
endmodule

// File: rtl/dma_rc_arb.sv
module dma_rc_arb #(
  parameter  int N_CH = 4,
  localparam int CH_W = (N_CH > 1) ? $clog2(N_CH) : 1
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic [N_CH-1:0] req_i,
  input  logic            op_done_i,
  output logic [N_CH-1:0] gnt_o,
  output logic            busy_o,
  output logic [CH_W-1:0] ch_o
);
  logic [CH_W-1:0] pick;
  logic            any_req;

  always_comb begin
    pick    = '0;
    any_req = |req_i;
    for (int i = N_CH - 1; i >= 0; i--) begin
      if (req_i[i]) pick = CH_W'(i);
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      gnt_o  <= '0;
      busy_o <= 1'b0;
      ch_o   <= '0;
    end else if (busy_o) begin
      if (op_done_i) begin
        gnt_o  <= '0;
        busy_o <= 1'b0;
      end
    end else if (any_req) begin
      gnt_o  <= {{(N_CH-1){1'b0}}, 1'b1} << pick;
      busy_o <= 1'b1;
      ch_o   <= pick;
    end
  end

  assert_one_grant_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(gnt_o));

  assert_grant_held_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_o && !op_done_i) |=> $stable(gnt_o));
endmodule

// File: rtl/dma_run_ctrl.sv
module dma_run_ctrl
  import dma_rc_pkg::*;
#(
  parameter  int N_CH  = 4,
  parameter  int CNT_W = 8,
  localparam int CH_W  = (N_CH > 1) ? $clog2(N_CH) : 1
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              glb_en_i,
  input  logic [N_CH-1:0]   ch_en_i,
  input  logic [N_CH-1:0]   nonstop_i,
  input  logic [N_CH-1:0]   cancel_i,
  input  logic [N_CH-1:0]   start_i,
  input  logic              cfg_we_i,
  input  logic [CH_W-1:0]   cfg_ch_i,
  input  logic [CNT_W-1:0]  cfg_len_i,
  input  logic              op_done_i,
  output logic [N_CH-1:0]   gnt_o,
  output logic              op_busy_o,
  output logic [CH_W-1:0]   op_ch_o,
  output logic [2*N_CH-1:0] state_o,
  output logic [N_CH-1:0]   done_o
);
  logic [CNT_W-1:0] cfg_len_q [N_CH];
  logic [N_CH-1:0]  req;
  logic [N_CH-1:0]  run_ok;
  ch_state_e        st [N_CH];

  // configuration is never touched by cancel
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int i = 0; i < N_CH; i++) cfg_len_q[i] <= '0;
    end else if (cfg_we_i) begin
      cfg_len_q[cfg_ch_i] <= cfg_len_i;
    end
  end

  dma_rc_arb #(.N_CH(N_CH)) arb_i (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .req_i     (req),
    .op_done_i (op_done_i),
    .gnt_o     (gnt_o),
    .busy_o    (op_busy_o),
    .ch_o      (op_ch_o)
  );

  for (genvar g = 0; g < N_CH; g++) begin : g_ch
    assign run_ok[g] = (glb_en_i & ch_en_i[g]) | nonstop_i[g];

    dma_rc_chan #(.CNT_W(CNT_W)) chan_i (
      .clk_i     (clk_i),
      .rst_ni    (rst_ni),
      .start_i   (start_i[g]),
      .len_i     (cfg_len_q[g]),
      .run_ok_i  (run_ok[g]),
      .cancel_i  (cancel_i[g]),
      .gnt_i     (gnt_o[g]),
      .op_done_i (op_done_i),
      .req_o     (req[g]),
      .state_o   (st[g]),
      .done_o    (done_o[g])
    );

    assign state_o[2*g +: 2] = st[g];

    assert_nonstop_keeps_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (st[g] == CH_RUN && nonstop_i[g]) |=> (st[g] == CH_RUN || st[g] == CH_IDLE));

    assert_hold_no_grant_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (st[g] == CH_HOLD) |-> !gnt_o[g]);
  end
endmodule

// File: tb/dma_run_ctrl_tb_top.sv
module dma_run_ctrl_tb_top;
  localparam int N   = 4;
  localparam int CW  = 8;
  localparam int HW  = 2;
  localparam int LAT = 3;

  logic          clk = 1'b0;
  logic          rst_n;
  logic          glb_en;
  logic [N-1:0]  ch_en, nonstop, cancel, start;
  logic          cfg_we;
  logic [HW-1:0] cfg_ch;
  logic [CW-1:0] cfg_len;
  logic          op_done;
  logic [N-1:0]  gnt;
  logic          op_busy;
  logic [HW-1:0] op_ch;
  logic [2*N-1:0] state;
  logic [N-1:0]  done;

  int n_chk = 0;
  int n_err = 0;
  int ops_seen [N];
  int dp_cnt = 0;
  int exp_q [$];
  bit finished = 1'b0;

  always #5 clk = ~clk;

  dma_run_ctrl #(.N_CH(N), .CNT_W(CW)) dut_i (
    .clk_i(clk), .rst_ni(rst_n), .glb_en_i(glb_en), .ch_en_i(ch_en),
    .nonstop_i(nonstop), .cancel_i(cancel), .start_i(start),
    .cfg_we_i(cfg_we), .cfg_ch_i(cfg_ch), .cfg_len_i(cfg_len),
    .op_done_i(op_done), .gnt_o(gnt), .op_busy_o(op_busy), .op_ch_o(op_ch),
    .state_o(state), .done_o(done)
  );

  task automatic check(string req, int act, int exp);
    n_chk++;
    if (act != exp) begin
      n_err++;
      $display("FAIL %s act=%0d exp=%0d", req, act, exp);
    end
  endtask

  function automatic int st(int c);
    return int'(state[2*c +: 2]);
  endfunction

  // one negedge step with the datapath model
  task automatic step();
    @(negedge clk);
    op_done = 1'b0;
    if (op_busy) begin
      if (dp_cnt == LAT - 1) begin
        op_done = 1'b1;
        dp_cnt  = 0;
        ops_seen[op_ch]++;
      end else begin
        dp_cnt++;
      end
    end
  endtask

  task automatic cfg(int c, int l);
    cfg_we = 1'b1; cfg_ch = HW'(c); cfg_len = CW'(l);
    step();
    cfg_we = 1'b0;
  endtask

  task automatic pulse_start(logic [N-1:0] m);
    start = m;
    step();
    start = '0;
  endtask

  task automatic wait_idle(int c);
    for (int k = 0; k < 300 && st(c) != 0; k++) step();
  endtask

  task automatic clr_ops();
    for (int c = 0; c < N; c++) ops_seen[c] = 0;
  endtask

  // scoreboard monitor
  always @(negedge clk) begin
    if (rst_n && done != '0) begin
      for (int c = 0; c < N; c++) begin
        if (done[c]) begin
          if (exp_q.size() == 0) check("R2 unexpected done", c, -1);
          else check("R2 done order", c, exp_q.pop_front());
        end
      end
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      n_err++; n_chk++;
      $display("FAIL R1 watchdog act=0 exp=1");
      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
    end
  end

  initial begin
    int bad;
    rst_n = 1'b0; glb_en = 1'b1; ch_en = '1; nonstop = '0; cancel = '0;
    start = '0; cfg_we = 1'b0; cfg_ch = '0; cfg_len = '0; op_done = 1'b0;
    clr_ops();
    repeat (3) step();
    check("R1 state", int'(state), 0);
    check("R1 grant", int'(gnt), 0);
    check("R1 busy", int'(op_busy), 0);
    check("R1 done", int'(done), 0);
    rst_n = 1'b1;
    step();

    // R2 / R10 basic run
    cfg(0, 3);
    exp_q.push_back(0);
    pulse_start(4'b0001);
    check("R10 active code", st(0), 1);
    wait_idle(0);
    check("R2 op count", ops_seen[0], 3);

    // R3 priority
    cfg(1, 2); cfg(2, 2); clr_ops();
    exp_q.push_back(1); exp_q.push_back(2);
    pulse_start(4'b0110);
    for (int k = 0; k < 10 && gnt == '0; k++) step();
    check("R3 lowest grant", int'(gnt), 2);
    check("R3 op_ch", int'(op_ch), 1);
    wait_idle(2);
    check("R3 ops ch1", ops_seen[1], 2);
    check("R3 ops ch2", ops_seen[2], 2);

    // R4 global suspend with operand in flight, R7 resume
    cfg(0, 5); cfg(1, 4); clr_ops();
    pulse_start(4'b0011);
    for (int k = 0; k < 100 && !(gnt[0] && !op_done && ops_seen[0] == 1); k++) step();
    glb_en = 1'b0;
    step();
    check("R4 draining code", st(0), 2);
    check("R4 other suspended", st(1), 3);
    for (int k = 0; k < 50 && st(0) != 3; k++) step();
    check("R4 in-flight completed", ops_seen[0], 2);
    repeat (5) step();
    check("R4 no grant while halted", int'(gnt), 0);
    check("R4 count frozen", ops_seen[0], 2);
    exp_q.push_back(0); exp_q.push_back(1);
    glb_en = 1'b1;
    wait_idle(0);
    check("R7 total ops ch0", ops_seen[0], 5);
    wait_idle(1);
    check("R7 total ops ch1", ops_seen[1], 4);

    // R5 per-channel suspend, R11 cancel beats resume, R8 config kept
    cfg(0, 4); cfg(2, 2); clr_ops();
    pulse_start(4'b0101);
    ch_en[0] = 1'b0;
    step();
    check("R5 ch0 suspended", st(0), 3);
    exp_q.push_back(2);
    wait_idle(2);
    check("R5 ch2 ran", ops_seen[2], 2);
    check("R5 ch0 still suspended", st(0), 3);
    check("R5 ch0 no ops", ops_seen[0], 0);
    cancel[0] = 1'b1; ch_en[0] = 1'b1;
    step();
    cancel = '0;
    check("R11 cancel wins", st(0), 0);
    repeat (4) step();
    check("R11 no grant after cancel", int'(gnt), 0);
    check("R8 no ops after cancel", ops_seen[0], 0);
    exp_q.push_back(0);
    pulse_start(4'b0001);
    wait_idle(0);
    check("R8 config length kept", ops_seen[0], 4);

    // R9 cancel ignored when active or idle
    cfg(1, 3); clr_ops();
    exp_q.push_back(1);
    pulse_start(4'b0010);
    cancel = 4'b1010;
    step();
    cancel = '0;
    check("R9 active unaffected", st(1), 1);
    check("R9 idle unaffected", st(3), 0);
    wait_idle(1);
    check("R9 ops complete", ops_seen[1], 3);

    // R6 nonstop ignores disables
    cfg(3, 3); clr_ops();
    nonstop[3] = 1'b1;
    exp_q.push_back(3);
    pulse_start(4'b1000);
    glb_en = 1'b0; ch_en[3] = 1'b0;
    bad = 0;
    for (int k = 0; k < 300 && st(3) != 0; k++) begin
      step();
      if (st(3) >= 2) bad++;
    end
    check("R6 never halted", bad, 0);
    check("R6 ops complete", ops_seen[3], 3);
    glb_en = 1'b1; ch_en = '1; nonstop = '0;

    repeat (5) step();
    check("R2 scoreboard drained", exp_q.size(), 0);
    finished = 1'b1;
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end
endmodule